// File: doc/BRIEF.md
# Analog Input Selection Settling Sequencer

This block is the control sequencer between the register interface of an analog-to-digital converter and the converter core. It runs on the converter clock. It owns the active input selection, which is a channel number plus a differential flag. A selection write does not take effect at once. The write passes through a short synchronising pipeline, and the sequencer then inserts a settling phase so that the input stage and the gain amplifier can stabilise.

The settling length depends on the kind of transition:

- A move to a single-ended input settles for a short interval.
- A move from a single-ended to a differential input settles for a longer interval built from the start-up and track-time fields.
- A move from one differential input to another gets no settling. It only takes effect through a disable/enable cycle.

Conversion starts that arrive while the sequencer is settling are held until settling ends. A selection write that lands during a conversion is deferred to the end of that conversion. A selection write in the tracking phase cuts tracking short.

The converter core and the gain amplifier appear only as timing. The sequencer issues a one-cycle start strobe, and the core answers with a one-cycle done pulse. All pins are plain control or status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `phase` is 0 (idle), `conv_start` is 0 and `force_busy` is 0. The phase codes are idle=0, start-up=1, settling=2, converting=3 and tracking=4. While `enable` is low, `phase` is idle from the edge after `enable` is sampled low, and other requests have no effect.
- R2: When `enable` is sampled high in idle, `phase` becomes start-up at that edge and the active selection is loaded from the latest written selection. Start-up lasts 4×(`cfg_startup`+1) cycles and is followed by tracking.
- R3: A selection write sampled at edge k reaches the sequencer two cycles later. In tracking, `phase` becomes settling at edge k+2, which cuts tracking short, and the new selection becomes active at that same edge.
- R4: A change whose target is single-ended, from either kind of input, settles for `cfg_track`+2 cycles and then goes to tracking.
- R5: A change from a single-ended to a differential input settles for 4×(`cfg_startup`+1)+2×(`cfg_track`+2) cycles.
- R6: A change from one differential input to another produces no settling phase and leaves the active selection unchanged. The next disable/enable cycle loads it.
- R7: A start request (`sw_start`, or `trig_pulse` while `trig_en` is high) that arrives during start-up or settling is held. Settling is always followed by at least one tracking cycle, and the held conversion starts on the edge after settling ends.
- R8: In tracking, a start request sampled at edge k makes `phase` converting at edge k. `conv_start` is high for exactly the first converting cycle. `trig_pulse` has no effect while `trig_en` is low. A `conv_done` sampled in converting returns `phase` to tracking at that edge.
- R9: A selection write that reaches the sequencer during a conversion is deferred. The active selection stays stable through the conversion. At the edge that samples `conv_done`, `phase` becomes settling and the new selection becomes active.
- R10: When several writes are pending, only the most recent selection is applied.
- R11: With `free_run` high, a new conversion starts on the edge after each tracking cycle begins. A pending change inserts its settling phase between the done pulse and the next tracking cycle, which lengthens the gap by exactly the settling duration.
- R12: A `force_wr` pulse with a single-ended active input enters settling for `cfg_track`+2 cycles, two cycles after it is sampled, and leaves the selection unchanged. With a differential active input the pulse is ignored. `force_busy` rises at the edge that samples `force_wr` and falls when that settling ends or when the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; a rising level re-runs start-up |
| sel_wr | input | 1 | Write strobe for the selection |
| sel_chan | input | CH_W | Channel number written with `sel_wr` |
| sel_diff | input | 1 | 1 = differential input, 0 = single-ended |
| force_wr | input | 1 | Request a settling phase with no change of selection |
| sw_start | input | 1 | Software conversion start request |
| trig_en | input | 1 | Enables the trigger input |
| trig_pulse | input | 1 | Trigger event that requests a conversion |
| free_run | input | 1 | Restart conversions back to back |
| cfg_startup | input | SU_W | Start-up length field |
| cfg_track | input | TH_W | Track-time field |
| conv_done | input | 1 | One-cycle end-of-conversion pulse from the core |
| conv_start | output | 1 | One-cycle start strobe to the core |
| phase | output | 3 | Current phase code |
| active_chan | output | CH_W | Channel presently applied to the core |
| active_diff | output | 1 | Differential flag of the applied input |
| force_busy | output | 1 | Forced settling pending or in progress |

## Verification
Every result has a fixed latency:

- The entry into settling comes two edges after the edge that samples a write.
- A start from tracking, and the return from a done pulse, take effect at the sampling edge itself.
- A held start takes effect one edge after settling ends.
- The exit from settling or start-up comes exactly the computed number of cycles after entry.

The bench turns each stimulus into phase-change records stamped with the cycle count at which they are due, and queues them before it drives the stimulus. A monitor samples at the falling edge, compares every observed phase change with the head of the queue (phase, cycle and channel), and flags any change that was not expected. Point checks on the strobe, the busy flag and the active selection are made at the falling edge of the cycle in which each value is due.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_STARTUP = 3'd1,
    PH_SETTLE  = 3'd2,
    PH_CONVERT = 3'd3,
    PH_TRACK   = 3'd4
  } phase_e;

  // Cycles spent in start-up after an enable.
  function automatic int unsigned startup_cycles(input int unsigned su);
    return 4 * (su + 1);
  endfunction

  // Cycles of settling for a change, chosen by the target kind
  // (source is single-ended whenever the target is differential).
  function automatic int unsigned settle_cycles(input logic to_diff,
                                                input int unsigned su,
                                                input int unsigned th);
    if (to_diff) return 4 * (su + 1) + 2 * (th + 2);
    return th + 2;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
// Delays a single-cycle request by STAGES clock edges.
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pipe_q <= '0;
        else if (clr) pipe_q <= '0;
        else          pipe_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pipe_q <= '0;
        else if (clr) pipe_q <= '0;
        else          pipe_q <= {pipe_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
// Down counter: load a value, count down while run is high, flag zero.
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_chan.sv
// Holds the most recently written selection and the applied selection.
module adc_seq_chan #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_diff,
  input  logic            apply,
  output logic            pend_diff,
  output logic [CH_W-1:0] act_chan,
  output logic            act_diff
);
  logic [CH_W-1:0] pend_chan_q;
  logic            pend_diff_q;
  logic [CH_W-1:0] act_chan_q;
  logic            act_diff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_chan_q <= '0;
      pend_diff_q <= 1'b0;
    end else if (wr) begin
      pend_chan_q <= wr_chan;
      pend_diff_q <= wr_diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_chan_q <= '0;
      act_diff_q <= 1'b0;
    end else if (apply) begin
      act_chan_q <= pend_chan_q;
      act_diff_q <= pend_diff_q;
    end
  end

  assign pend_diff = pend_diff_q;
  assign act_chan  = act_chan_q;
  assign act_diff  = act_diff_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int CH_W        = 5,
  parameter int SU_W        = 5,
  parameter int TH_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            sel_wr,
  input  logic [CH_W-1:0] sel_chan,
  input  logic            sel_diff,
  input  logic            force_wr,
  input  logic            sw_start,
  input  logic            trig_en,
  input  logic            trig_pulse,
  input  logic            free_run,
  input  logic [SU_W-1:0] cfg_startup,
  input  logic [TH_W-1:0] cfg_track,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [2:0]      phase,
  output logic [CH_W-1:0] active_chan,
  output logic            active_diff,
  output logic            force_busy
);
  import adc_seq_pkg::*;

  localparam int MAX_LEN = 4 * (2 ** SU_W) + 2 * ((2 ** TH_W) + 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_e ph_q, ph_d;
  logic chg_sync, frc_sync;
  logic chg_due_q, frc_due_q, start_pend_q, frc_in_settle_q, force_busy_q, conv_start_q;
  logic chg_now, frc_now, start_req;
  logic pend_diff;
  logic plan_go, plan_apply;
  logic [CNT_W-1:0] plan_val, startup_val;
  logic tmr_load, tmr_zero, tmr_run;
  logic [CNT_W-1:0] tmr_val;
  logic act_load, go_conv, settle_go, due_drop;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_chg_sync (
    .clk(clk), .rst_n(rst_n), .clr(~enable), .din(sel_wr), .dout(chg_sync)
  );

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_frc_sync (
    .clk(clk), .rst_n(rst_n), .clr(~enable), .din(force_wr), .dout(frc_sync)
  );

  adc_seq_chan #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wr_chan(sel_chan), .wr_diff(sel_diff),
    .apply(act_load), .pend_diff(pend_diff), .act_chan(active_chan), .act_diff(active_diff)
  );

  assign tmr_run = (ph_q == PH_STARTUP) || (ph_q == PH_SETTLE);

  adc_seq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .zero(tmr_zero)
  );

  assign chg_now   = chg_sync | chg_due_q;
  assign frc_now   = frc_sync | frc_due_q;
  assign start_req = sw_start | (trig_en & trig_pulse);

  assign startup_val = CNT_W'(startup_cycles(32'(cfg_startup)) - 1);

  // Settling decision for whatever change or force is due now.
  always_comb begin
    plan_go    = 1'b0;
    plan_apply = 1'b0;
    plan_val   = '0;
    if (chg_now && (!pend_diff || !active_diff)) begin
      plan_go    = 1'b1;
      plan_apply = 1'b1;
      plan_val   = CNT_W'(settle_cycles(pend_diff, 32'(cfg_startup), 32'(cfg_track)) - 1);
    end else if (frc_now && !active_diff) begin
      plan_go  = 1'b1;
      plan_val = CNT_W'(settle_cycles(1'b0, 32'(cfg_startup), 32'(cfg_track)) - 1);
    end
  end

  always_comb begin
    ph_d      = ph_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    act_load  = 1'b0;
    go_conv   = 1'b0;
    settle_go = 1'b0;
    due_drop  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (enable) begin
          ph_d     = PH_STARTUP;
          tmr_load = 1'b1;
          tmr_val  = startup_val;
          act_load = 1'b1;
        end
      end
      PH_STARTUP: begin
        if (tmr_zero) ph_d = PH_TRACK;
      end
      PH_SETTLE: begin
        if (plan_go) settle_go = 1'b1;
        else begin
          due_drop = chg_now | frc_now;
          if (tmr_zero) ph_d = PH_TRACK;
        end
      end
      PH_TRACK: begin
        if (plan_go) settle_go = 1'b1;
        else begin
          due_drop = chg_now | frc_now;
          if (start_req || start_pend_q || free_run) begin
            go_conv = 1'b1;
            ph_d    = PH_CONVERT;
          end
        end
      end
      PH_CONVERT: begin
        if (conv_done) begin
          if (plan_go) settle_go = 1'b1;
          else begin
            due_drop = chg_now | frc_now;
            ph_d     = PH_TRACK;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (settle_go) begin
      ph_d     = PH_SETTLE;
      tmr_load = 1'b1;
      tmr_val  = plan_val;
      act_load = plan_apply;
    end
    if (!enable) begin
      ph_d      = PH_IDLE;
      tmr_load  = 1'b0;
      act_load  = 1'b0;
      go_conv   = 1'b0;
      settle_go = 1'b0;
      due_drop  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q            <= PH_IDLE;
      chg_due_q       <= 1'b0;
      frc_due_q       <= 1'b0;
      start_pend_q    <= 1'b0;
      frc_in_settle_q <= 1'b0;
      force_busy_q    <= 1'b0;
      conv_start_q    <= 1'b0;
    end else begin
      ph_q         <= ph_d;
      conv_start_q <= go_conv;

      if (!enable || settle_go || due_drop) begin
        chg_due_q <= 1'b0;
        frc_due_q <= 1'b0;
      end else begin
        if (chg_sync) chg_due_q <= 1'b1;
        if (frc_sync) frc_due_q <= 1'b1;
      end

      if (!enable || ph_q == PH_IDLE || go_conv) start_pend_q <= 1'b0;
      else if (start_req)                         start_pend_q <= 1'b1;

      if (settle_go)
        frc_in_settle_q <= frc_now | ((ph_q == PH_SETTLE) & frc_in_settle_q);
      else if (ph_d != PH_SETTLE)
        frc_in_settle_q <= 1'b0;

      if (!enable)                     force_busy_q <= 1'b0;
      else if (force_wr)               force_busy_q <= 1'b1;
      else if (due_drop && frc_now)    force_busy_q <= 1'b0;
      else if (ph_q == PH_SETTLE && ph_d == PH_TRACK && frc_in_settle_q)
                                       force_busy_q <= 1'b0;
    end
  end

  assign phase      = ph_q;
  assign conv_start = conv_start_q;
  assign force_busy = force_busy_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            conv_start,
  input logic [2:0]      phase,
  input logic [CH_W-1:0] active_chan,
  input logic            active_diff
);
  import adc_seq_pkg::*;

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> phase == PH_IDLE);

  assert_leave_idle_to_startup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> phase == PH_STARTUP);

  assert_diff_swap_only_startup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_diff) && active_diff && !$stable(active_chan)) |-> phase == PH_STARTUP);

  assert_settle_exit_no_convert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_SETTLE && phase != PH_SETTLE) |-> (phase == PH_TRACK || phase == PH_IDLE));

  assert_start_strobe_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (phase == PH_CONVERT && $past(phase) == PH_TRACK));

  assert_chan_stable_in_convert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_CONVERT && phase == PH_CONVERT) |-> ($stable(active_chan) && $stable(active_diff)));

  assert_chan_moves_on_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_chan) |-> (phase == PH_SETTLE || phase == PH_STARTUP));
endmodule

bind adc_seq_top adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .conv_start(conv_start),
  .phase(phase), .active_chan(active_chan), .active_diff(active_diff)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
  localparam int CH_W = 5;
  localparam int SU_W = 5;
  localparam int TH_W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enable, sel_wr, sel_diff, force_wr, sw_start, trig_en, trig_pulse, free_run, conv_done;
  logic [CH_W-1:0] sel_chan;
  logic [SU_W-1:0] cfg_startup;
  logic [TH_W-1:0] cfg_track;
  logic conv_start, active_diff, force_busy;
  logic [2:0] phase;
  logic [CH_W-1:0] active_chan;

  adc_seq_top #(.CH_W(CH_W), .SU_W(SU_W), .TH_W(TH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sel_wr(sel_wr), .sel_chan(sel_chan),
    .sel_diff(sel_diff), .force_wr(force_wr), .sw_start(sw_start), .trig_en(trig_en),
    .trig_pulse(trig_pulse), .free_run(free_run), .cfg_startup(cfg_startup),
    .cfg_track(cfg_track), .conv_done(conv_done), .conv_start(conv_start), .phase(phase),
    .active_chan(active_chan), .active_diff(active_diff), .force_busy(force_busy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct { int ph; int at; int ch; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic void expect_ph(int ph, int at, int ch, string tag);
    exp_t e;
    e.ph = ph; e.at = at; e.ch = ch; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  // Monitor: every phase change must match the head of the queue.
  int last_ph = 0;
  always @(negedge clk) begin
    if (rst_n && !finished && int'(phase) != last_ph) begin
      if (exp_q.size() == 0) begin
        check("R3", "unexpected phase change", int'(phase), last_ph);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "phase", int'(phase), e.ph);
        check(e.tag, "phase change cycle", cyc, e.at);
        check(e.tag, "active channel", int'(active_chan), e.ch);
      end
      last_ph = int'(phase);
    end
  end

  task automatic at(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_wr(int c, int ch, bit diff);
    at(c);
    sel_wr = 1'b1; sel_chan = CH_W'(ch); sel_diff = diff;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic pulse_start(int c);
    at(c); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_trig(int c);
    at(c); trig_pulse = 1'b1; @(negedge clk); trig_pulse = 1'b0;
  endtask

  task automatic pulse_done(int c);
    at(c); conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_force(int c);
    at(c); force_wr = 1'b1; @(negedge clk); force_wr = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 5000);
    finish_run();
  end

  // cfg_startup=1, cfg_track=1: start-up 8, single-ended settle 3, to-differential settle 14.
  initial begin
    int t;
    rst_n = 1'b0; enable = 1'b0; sel_wr = 1'b0; sel_chan = '0; sel_diff = 1'b0;
    force_wr = 1'b0; sw_start = 1'b0; trig_en = 1'b0; trig_pulse = 1'b0;
    free_run = 1'b0; conv_done = 1'b0; cfg_startup = SU_W'(1); cfg_track = TH_W'(1);
    repeat (3) @(negedge clk);
    check("R1", "reset phase", int'(phase), 0);
    check("R1", "reset conv_start", int'(conv_start), 0);
    check("R1", "reset force_busy", int'(force_busy), 0);
    rst_n = 1'b1;

    // R1: write while disabled does not leave idle.
    t = cyc + 1;
    pulse_wr(t, 3, 1'b0);
    at(t + 4);
    check("R1", "idle while disabled", int'(phase), 0);

    // R2: enable runs start-up with the written selection.
    t = cyc + 1;
    expect_ph(1, t + 1, 3, "R2");
    expect_ph(4, t + 9, 3, "R2");
    at(t); enable = 1'b1;
    at(t + 12);

    // R3/R4/R7/R8: single-ended change, start held during settling.
    t = cyc + 1;
    expect_ph(2, t + 3, 5, "R3");
    expect_ph(4, t + 6, 5, "R4");
    expect_ph(3, t + 7, 5, "R7");
    expect_ph(4, t + 11, 5, "R8");
    pulse_wr(t, 5, 1'b0);
    pulse_start(t + 4);
    at(t + 7);
    check("R8", "strobe on first converting cycle", int'(conv_start), 1);
    at(t + 8);
    check("R8", "strobe one cycle only", int'(conv_start), 0);
    pulse_done(t + 10);

    // R9/R10: writes during conversion are deferred; latest one wins.
    t = cyc + 1;
    expect_ph(3, t + 1, 5, "R8");
    expect_ph(2, t + 13, 9, "R9");
    expect_ph(4, t + 16, 9, "R10");
    pulse_start(t);
    pulse_wr(t + 2, 7, 1'b0);
    at(t + 6);
    check("R9", "active held during conversion", int'(active_chan), 5);
    pulse_wr(t + 6, 9, 1'b0);
    pulse_done(t + 12);
    at(t + 13);
    check("R10", "latest selection applied", int'(active_chan), 9);
    at(t + 17);

    // R5: single-ended to differential.
    t = cyc + 1;
    expect_ph(2, t + 3, 2, "R5");
    expect_ph(4, t + 17, 2, "R5");
    pulse_wr(t, 2, 1'b1);
    at(t + 4);
    check("R5", "differential flag applied", int'(active_diff), 1);
    at(t + 18);

    // R6: differential to differential needs disable/enable.
    t = cyc + 1;
    pulse_wr(t, 4, 1'b1);
    at(t + 6);
    check("R6", "no settling", int'(phase), 4);
    check("R6", "active unchanged", int'(active_chan), 2);
    expect_ph(0, t + 8, 2, "R1");
    expect_ph(1, t + 10, 4, "R6");
    expect_ph(4, t + 18, 4, "R2");
    at(t + 7); enable = 1'b0;
    at(t + 9); enable = 1'b1;
    at(t + 19);
    check("R6", "differential kept after re-enable", int'(active_diff), 1);

    // R12: force with differential active is dropped.
    t = cyc + 1;
    pulse_force(t);
    check("R12", "force_busy raised", int'(force_busy), 1);
    at(t + 4);
    check("R12", "force_busy cleared on drop", int'(force_busy), 0);
    check("R12", "no settling on differential", int'(phase), 4);

    // R4: differential back to single-ended.
    t = cyc + 1;
    expect_ph(2, t + 3, 6, "R4");
    expect_ph(4, t + 6, 6, "R4");
    pulse_wr(t, 6, 1'b0);
    at(t + 7);

    // R12: forced settling on single-ended input.
    t = cyc + 1;
    expect_ph(2, t + 3, 6, "R12");
    expect_ph(4, t + 6, 6, "R12");
    pulse_force(t);
    at(t + 5);
    check("R12", "force_busy during settling", int'(force_busy), 1);
    at(t + 6);
    check("R12", "force_busy clears at end", int'(force_busy), 0);
    at(t + 7);

    // R8: trigger ignored while disabled, honoured when enabled.
    t = cyc + 1;
    pulse_trig(t);
    at(t + 2);
    check("R8", "trigger ignored without trig_en", int'(phase), 4);
    trig_en = 1'b1;
    t = cyc + 1;
    expect_ph(3, t + 1, 6, "R8");
    expect_ph(4, t + 4, 6, "R8");
    pulse_trig(t);
    pulse_done(t + 3);
    at(t + 5);
    trig_en = 1'b0;

    // R11: free running with a change in the middle.
    t = cyc + 1;
    expect_ph(3, t + 1, 6, "R11");
    expect_ph(4, t + 4, 6, "R11");
    expect_ph(3, t + 5, 6, "R11");
    expect_ph(2, t + 10, 8, "R11");
    expect_ph(4, t + 13, 8, "R11");
    expect_ph(3, t + 14, 8, "R11");
    expect_ph(4, t + 17, 8, "R11");
    at(t); free_run = 1'b1;
    pulse_done(t + 3);
    pulse_wr(t + 5, 8, 1'b0);
    pulse_done(t + 9);
    at(t + 14); free_run = 1'b0;
    pulse_done(t + 16);
    at(t + 20);
    check("R11", "remains tracking after free run", int'(phase), 4);

    check("R3", "outstanding expected phase changes", exp_q.size(), 0);
    finish_run();
  end
endmodule